// File: doc/BRIEF.md
# CPU Clock Source and Divider Switchover Controller

This block picks the clock that drives the CPU. It can use a fast main oscillator, optionally divided by 1, 2, 4, 8 or 16, or a slow subsystem oscillator. Both oscillators arrive as single-cycle tick pulses in the block's own clock domain. The block produces a registered CPU clock-enable pulse, `cpu_ce`, that is high once per CPU cycle.

Software writes a control byte to change the source or the division ratio. A new setting never takes effect at once. The block keeps running on the old setting for a settling interval, counted in CPU cycles of the old clock. It then changes over at the end of an old CPU cycle. The settling interval depends on the kind of change and on the ratio in force before it.

A status bit in the readback shows the source that is really driving the CPU, not the one that was requested. Writes that arrive during a pending changeover are held, and only the newest held write is kept. A forbidden request, a ratio change combined with a move to the subsystem clock, is partly applied and is recorded in a sticky error flag.

Top module: `cpu_clk_switch`

## Requirements
- R1: After reset, `rd_data` reads 0x00. This means the main source at divide-by-1, with the status bit and the error flag clear. `cpu_ce` is low.
- R2: The readback fields are as follows. Bits [2:0] hold the requested ratio code. Bit 4 holds the requested source (0 = main, 1 = subsystem). Bit 5 shows the active source. Bit 7 is the sticky error flag. Bits 3 and 6 read 0. Bits 5 and 7 of a write are ignored.
- R3: On the main source, ratio code k (0 to 4) gives one `cpu_ce` pulse for every 2^k `main_tick` pulses.
- R4: A write with ratio code 5, 6 or 7 leaves the ratio unchanged.
- R5: On the subsystem source, `cpu_ce` pulses once for each `sub_tick` pulse.
- R6: A ratio-only change on the main source takes effect after 16 >> k old-clock CPU cycles, where k is the old ratio code. These cycles are counted after the cycle that accepts the write.
- R7: A move from the subsystem source to the main source takes effect after 1 old-clock CPU cycle.
- R8: A move from the main source to the subsystem source takes effect after SUB_DELAY >> k old-clock CPU cycles, with a minimum of 1. The default gives 38 cycles at code 2.
- R9: A write that both changes the ratio and requests main-to-subsystem applies only the source change. The old ratio is kept and bit 7 is set and stays set until reset.
- R10: A write that changes the ratio and requests subsystem-to-main applies both changes.
- R11: A write accepted during a pending changeover does not alter the readback. The newest such write is applied after the changeover completes.
- R12: The active-source bit changes only in a cycle where `cpu_ce` is high, and only to the previously requested source.
- R13: `cpu_ce` is registered. It is high one cycle after a tick of the active source completes a CPU cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_tick | input | 1 | One-cycle pulse per main oscillator period |
| sub_tick | input | 1 | One-cycle pulse per subsystem oscillator period |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register readback, including status and error bits |
| cpu_ce | output | 1 | CPU clock-enable pulse |

## Verification
The bound assertions check four things on every cycle:
- each `cpu_ce` pulse comes from a tick of the source that was active;
- the active-source bit flips only on a CPU cycle boundary and only toward the requested source;
- the error flag is sticky;
- the readback ratio is never a reserved code.

Only the bench scenarios can show the exact settling counts for each kind of switch, the division rates and the held-write ordering. They can also show that the forbidden combined request keeps the old ratio. The bench covers these with measured pulse counts and with a cycle-by-cycle reference model.

// File: rtl/cksw_pkg.sv
package cksw_pkg;

    // Fixed control byte layout (software decodes these positions)
    localparam int RATIO_W   = 3;
    localparam int BIT_REQ   = 4;
    localparam int BIT_ACT   = 5;
    localparam int BIT_ERR   = 7;
    localparam int DATA_W    = 8;

    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_SUB  = 1'b1
    } src_e;

endpackage

// File: rtl/cksw_prescale.sv
module cksw_prescale
    import cksw_pkg::*;
#(
    parameter int NUM_DIV = 5,
    localparam int PC_W   = (NUM_DIV > 1) ? NUM_DIV - 1 : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               main_tick,
    input  logic               sub_tick,
    input  src_e               src,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               resync,
    output logic               ce_now
);

    logic [PC_W-1:0] pcnt_d, pcnt_q;
    logic [PC_W-1:0] wrap_val;

    always_comb begin
        wrap_val = PC_W'((1 << ratio) - 1);
        if (src == SRC_SUB) begin
            ce_now = sub_tick;
        end else begin
            ce_now = main_tick && (pcnt_q == wrap_val);
        end

        pcnt_d = pcnt_q;
        if (resync) begin
            pcnt_d = '0;
        end else if ((src == SRC_MAIN) && main_tick) begin
            pcnt_d = ce_now ? '0 : pcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_d;
        end
    end

endmodule

// File: rtl/cksw_decode.sv
module cksw_decode
    import cksw_pkg::*;
#(
    parameter int NUM_DIV   = 5,
    parameter int SUB_DELAY = 152,
    parameter int CNT_W     = 8
) (
    input  logic [DATA_W-1:0]  req,
    input  logic [RATIO_W-1:0] act_ratio,
    input  src_e               act_src,
    output logic [RATIO_W-1:0] new_ratio,
    output src_e               new_src,
    output logic               change,
    output logic               illegal,
    output logic [CNT_W-1:0]   delay
);

    localparam int BASE_DELAY = 1 << (NUM_DIV - 1);

    logic [CNT_W-1:0] div_tab [NUM_DIV];
    logic [CNT_W-1:0] sub_tab [NUM_DIV];

    // Settling counts for each old ratio code
    for (genvar k = 0; k < NUM_DIV; k++) begin : g_tab
        localparam int SUB_RAW = SUB_DELAY >> k;
        assign div_tab[k] = CNT_W'(BASE_DELAY >> k);
        assign sub_tab[k] = CNT_W'((SUB_RAW < 1) ? 1 : SUB_RAW);
    end

    logic [RATIO_W-1:0] want_ratio;
    logic               ratio_ok;
    logic               to_sub;
    logic               to_main;

    always_comb begin
        want_ratio = req[RATIO_W-1:0];
        ratio_ok   = (int'(want_ratio) < NUM_DIV);
        new_src    = src_e'(req[BIT_REQ]);
        to_sub     = (act_src == SRC_MAIN) && (new_src == SRC_SUB);
        to_main    = (act_src == SRC_SUB) && (new_src == SRC_MAIN);

        new_ratio = ratio_ok ? want_ratio : act_ratio;
        illegal   = 1'b0;
        if (to_sub && (new_ratio != act_ratio)) begin
            illegal   = 1'b1;
            new_ratio = act_ratio;
        end

        change = (new_src != act_src) || (new_ratio != act_ratio);

        if (to_main || (act_src == SRC_SUB)) begin
            delay = CNT_W'(1);
        end else if (to_sub) begin
            delay = sub_tab[act_ratio];
        end else begin
            delay = div_tab[act_ratio];
        end
    end

endmodule

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch
    import cksw_pkg::*;
#(
    parameter int NUM_DIV   = 5,
    parameter int SUB_DELAY = 152,
    localparam int BASE_DELAY = 1 << (NUM_DIV - 1),
    localparam int MAX_DELAY  = (SUB_DELAY > BASE_DELAY) ? SUB_DELAY : BASE_DELAY,
    localparam int CNT_W      = $clog2(MAX_DELAY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_tick,
    input  logic              sub_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              cpu_ce
);

    typedef struct packed {
        logic [RATIO_W-1:0] act_ratio;
        src_e               act_src;
        logic [RATIO_W-1:0] tgt_ratio;
        src_e               tgt_src;
        logic               busy;
        logic [CNT_W-1:0]   left;
        logic               held_v;
        logic [DATA_W-1:0]  held;
        logic               err;
        logic               ce;
    } state_t;

    state_t s_d, s_q;

    logic               ce_now;
    logic               apply;
    logic [DATA_W-1:0]  dec_req;
    logic [RATIO_W-1:0] dec_ratio;
    src_e               dec_src;
    logic               dec_change;
    logic               dec_illegal;
    logic [CNT_W-1:0]   dec_delay;

    cksw_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_tick (main_tick),
        .sub_tick  (sub_tick),
        .src       (s_q.act_src),
        .ratio     (s_q.act_ratio),
        .resync    (apply),
        .ce_now    (ce_now)
    );

    assign dec_req = wr_en ? wr_data : s_q.held;

    cksw_decode #(
        .NUM_DIV   (NUM_DIV),
        .SUB_DELAY (SUB_DELAY),
        .CNT_W     (CNT_W)
    ) u_dec (
        .req       (dec_req),
        .act_ratio (s_q.act_ratio),
        .act_src   (s_q.act_src),
        .new_ratio (dec_ratio),
        .new_src   (dec_src),
        .change    (dec_change),
        .illegal   (dec_illegal),
        .delay     (dec_delay)
    );

    always_comb begin
        s_d   = s_q;
        apply = 1'b0;
        if (s_q.busy) begin
            if (wr_en) begin
                s_d.held_v = 1'b1;
                s_d.held   = wr_data;
            end
            if (ce_now) begin
                if (s_q.left == CNT_W'(1)) begin
                    apply         = 1'b1;
                    s_d.busy      = 1'b0;
                    s_d.act_ratio = s_q.tgt_ratio;
                    s_d.act_src   = s_q.tgt_src;
                end else begin
                    s_d.left = s_q.left - 1'b1;
                end
            end
        end else if (wr_en || s_q.held_v) begin
            s_d.held_v    = 1'b0;
            s_d.tgt_ratio = dec_ratio;
            s_d.tgt_src   = dec_src;
            s_d.err       = s_q.err | dec_illegal;
            if (dec_change) begin
                s_d.busy = 1'b1;
                s_d.left = dec_delay;
            end
        end
        s_d.ce = ce_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{act_ratio: '0, act_src: SRC_MAIN, tgt_ratio: '0, tgt_src: SRC_MAIN,
                     busy: 1'b0, left: '0, held_v: 1'b0, held: '0, err: 1'b0, ce: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data                   = '0;
        rd_data[RATIO_W-1:0]      = s_q.tgt_ratio;
        rd_data[BIT_REQ]          = s_q.tgt_src;
        rd_data[BIT_ACT]          = s_q.act_src;
        rd_data[BIT_ERR]          = s_q.err;
    end

    assign cpu_ce = s_q.ce;

endmodule

// File: rtl/cpu_clk_switch_chk.sv
module cpu_clk_switch_chk #(
    parameter int NUM_DIV = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       main_tick,
    input logic       sub_tick,
    input logic [7:0] rd_data,
    input logic       cpu_ce
);

    // R5
    sub_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && $past(rd_data[5])) |-> $past(sub_tick));

    // R13
    main_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && !$past(rd_data[5])) |-> $past(main_tick));

    // R12
    switch_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[5] != $past(rd_data[5])) |-> cpu_ce);

    // R12
    switch_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[5] != $past(rd_data[5])) |-> (rd_data[5] == $past(rd_data[4])));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_data[7]) |-> rd_data[7]);

    // R4
    ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_data[2:0]) < NUM_DIV);

endmodule

bind cpu_clk_switch cpu_clk_switch_chk #(.NUM_DIV(NUM_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_tick (main_tick),
    .sub_tick  (sub_tick),
    .rd_data   (rd_data),
    .cpu_ce    (cpu_ce)
);

// File: tb/tb_cpu_clk_switch.sv
`timescale 1ns/1ps
module tb_cpu_clk_switch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_tick = 1'b0;
    logic       sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cpu_ce;

    always #5 clk = ~clk;

    cpu_clk_switch dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_tick (main_tick),
        .sub_tick  (sub_tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .cpu_ce    (cpu_ce)
    );

    localparam int SUB_DLY = 152;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int mt_per = 1;
    string cur_req = "R13";
    logic [7:0] obs_rd;
    logic       obs_ce;

    // Behavioural reference state
    int m_adiv = 0, m_asrc = 0, m_tdiv = 0, m_tsrc = 0, m_busy = 0, m_cnt = 0;
    int m_hv = 0, m_hd = 0, m_err = 0, m_pcnt = 0, m_ce = 0;

    function automatic int m_rd();
        return (m_err << 7) | (m_asrc << 5) | (m_tsrc << 4) | m_tdiv;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_step(input int wr, input int wd, input int mt, input int st);
        int ce_now, nd, ns, ill, chg, dly, d, old_src, old_div, apply;
        old_src = m_asrc;
        old_div = m_adiv;
        ce_now = old_src ? st : ((mt != 0) && (m_pcnt == (1 << old_div) - 1));
        apply = 0;
        if (m_busy) begin
            if (wr) begin m_hv = 1; m_hd = wd; end
            if (ce_now) begin
                if (m_cnt == 1) begin
                    apply = 1; m_busy = 0; m_adiv = m_tdiv; m_asrc = m_tsrc;
                end else m_cnt--;
            end
        end else if (wr || m_hv) begin
            d = wr ? wd : m_hd;
            m_hv = 0;
            ns = (d >> 4) & 1;
            nd = ((d & 7) < 5) ? (d & 7) : old_div;
            ill = 0;
            if (old_src == 0 && ns == 1 && nd != old_div) begin ill = 1; nd = old_div; end
            chg = (ns != old_src) || (nd != old_div);
            if (old_src == 1) dly = 1;
            else if (ns == 1) begin dly = SUB_DLY >> old_div; if (dly < 1) dly = 1; end
            else dly = 16 >> old_div;
            m_tdiv = nd; m_tsrc = ns;
            if (ill) m_err = 1;
            if (chg) begin m_busy = 1; m_cnt = dly; end
        end
        if (apply) m_pcnt = 0;
        else if (old_src == 0 && mt) m_pcnt = ce_now ? 0 : m_pcnt + 1;
        m_ce = ce_now;
    endtask

    // One cycle: compare, then drive next inputs and advance the model
    task automatic tick(input int wr, input int wd);
        int mt, st;
        @(negedge clk);
        obs_rd = rd_data;
        obs_ce = cpu_ce;
        check({cur_req, " rd_data"}, rd_data, m_rd());
        check({cur_req, " cpu_ce"}, cpu_ce, m_ce);
        mt = ((cyc % mt_per) == 0) ? 1 : 0;
        st = ((cyc % 8) == 0) ? 1 : 0;
        main_tick = mt[0];
        sub_tick  = st[0];
        wr_en     = wr[0];
        wr_data   = wd[7:0];
        model_step(wr, wd, mt, st);
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0);
    endtask

    initial begin
        #(1_500_000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        tick(0, 0);
        check("R1 reset rd_data", obs_rd, 8'h00);
        check("R1 reset cpu_ce", obs_ce, 0);

        // R6 + R2: ratio 0 -> 1, write bit 5 set (ignored)
        cur_req = "R6";
        tick(1, 8'h21);
        tick(0, 0);
        check("R2 readback ignores bit5", obs_rd, 8'h01);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            tick(0, 0);
            if (!obs_ce) break;
            n++;
        end
        check("R6 settle run at ratio 0", n, 16);
        idle(10);

        // R3: ratio 2 rate
        cur_req = "R3";
        tick(1, 8'h02);
        idle(40);
        n = 0;
        for (int i = 0; i < 64; i++) begin tick(0, 0); n += obs_ce; end
        check("R3 divide-by-4 pulses in 64", n, 16);

        // R4: reserved ratio code ignored
        cur_req = "R4";
        tick(1, 8'h06);
        idle(5);
        check("R4 reserved code keeps ratio", obs_rd, 8'h02);

        // R8: main -> sub at ratio 2
        cur_req = "R8";
        tick(1, 8'h12);
        tick(0, 0);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            tick(0, 0);
            n += obs_ce;
            if (obs_rd[5]) begin
                check("R12 status flips with cpu_ce", obs_ce, 1);
                break;
            end
        end
        check("R8 main to sub settle pulses", n, 38);

        // R5: subsystem rate
        cur_req = "R5";
        idle(20);
        n = 0;
        for (int i = 0; i < 64; i++) begin tick(0, 0); n += obs_ce; end
        check("R5 sub pulses in 64", n, 8);

        // R7: sub -> main
        cur_req = "R7";
        tick(1, 8'h02);
        tick(0, 0);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            tick(0, 0);
            n += obs_ce;
            if (!obs_rd[5]) break;
        end
        check("R7 sub to main settle pulses", n, 1);

        // R9: illegal combined request
        cur_req = "R9";
        mt_per = 3;
        idle(10);
        tick(1, 8'h13);
        for (int i = 0; i < 2000; i++) begin tick(0, 0); if (obs_rd[5]) break; end
        check("R9 source applied, ratio kept, error set", obs_rd, 8'hB2);

        // R10: combined sub -> main with ratio change
        cur_req = "R10";
        tick(1, 8'h04);
        for (int i = 0; i < 200; i++) begin tick(0, 0); if (!obs_rd[5]) break; end
        idle(3);
        check("R10 source and ratio applied", obs_rd, 8'h84);

        // R11: held writes during a pending switch
        cur_req = "R11";
        mt_per = 1;
        idle(20);
        tick(1, 8'h10);
        tick(1, 8'h03);
        tick(1, 8'h01);
        idle(2);
        check("R11 readback unchanged while pending", obs_rd, 8'h94);
        for (int i = 0; i < 2000; i++) begin tick(0, 0); if (obs_rd[5]) break; end
        for (int i = 0; i < 200; i++) begin tick(0, 0); if (!obs_rd[5]) break; end
        idle(40);
        check("R11 newest held write applied", obs_rd, 8'h81);

        // R13: mixed traffic under lockstep comparison
        cur_req = "R13";
        mt_per = 2;
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 40) == 0) tick(1, $urandom % 256);
            else tick(0, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule